// File: doc/BRIEF.md
# I2C Target Controller with 7-bit and 10-bit Addressing

This block is the target side of an I2C bus, clocked by the system clock. It synchronises SCL and SDA and finds Start, Repeated Start and Stop. It shifts in an address byte and compares it with a programmable own-address register. It then acknowledges the byte and passes it to a local host through a one-byte data register. The host sees a set of flags: buffer-full, overflow, update-address, read/write and interrupt. Both bus lines are driven as open-drain pull-down enables (`scl_oe`, `sda_oe`). When an enable is high the pad pulls the line low.

A 10-bit address is matched in two phases. The host first loads `11110,A9,A8,0` into the address register. After the high byte is acknowledged, the block holds SCL low until the host writes the low address byte. After the low byte matches, the block holds SCL low again until the host writes the high byte back. For a read, the master sends a Repeated Start and then the high byte with R/W=1. When the block transmits, it holds SCL low before every byte. Only the host can release it, by pulsing `rel_set` after loading the data.

The controller is one state machine. Its states are:
- IDLE: waiting for Start.
- ADDR: shifting an address byte.
- RX: shifting a data byte.
- ACK: driving the acknowledge bit.
- UAWAIT: SCL held, waiting for an address update.
- TXWAIT: SCL held, waiting for the release.
- TX: shifting data out.
- TXACK: sampling the master's acknowledge.

Its transitions are:
- IDLE→ADDR on Start.
- Any state→ADDR on Repeated Start, and any state→IDLE on Stop.
- ADDR→ACK on an accepted match, and ADDR→IDLE on a mismatch or overflow.
- RX→ACK or RX→IDLE by the same rule.
- ACK→RX, ACK→UAWAIT or ACK→TXWAIT at the 9th falling edge.
- UAWAIT→ADDR (low byte pending) or UAWAIT→RX on an address write.
- TXWAIT→TX on release.
- TX→TXACK at the 8th falling edge.
- TXACK→TXWAIT on master ACK, and TXACK→IDLE on master NACK.

Top module: `i2c_target_ctl`

## Requirements
- R1: After reset both line enables are low and all flags and the data register read 0. SDA falling while SCL is high (Start) begins a new address byte from any state. SDA rising while SCL is high (Stop) returns the block to idle with both lines released.
- R2: Bits are sampled on SCL rising, MSB first. In 7-bit mode (`ten_mode`=0), byte bits [7:1] are compared with address register bits [7:1] at the 8th SCL fall, and bit 0 is the direction (1 = read). On a match with `buf_full` and `ovf_flag` both clear, the block does three things. It pulls SDA low through the 9th clock, loads the byte into the data register, and sets `buf_full`. `rw_flag` follows bit 0.
- R3: `irq_flag` is set at the 9th SCL fall of every acknowledged byte and of every transmitted byte that the master acknowledges. Only `irq_clr` clears it.
- R4: A byte that does not match is not acknowledged and changes no flag. Further bytes are ignored until the next Start.
- R5: If `buf_full` or `ovf_flag` is set when a matching address byte or a data byte completes, no ACK is given, the data register is kept and the block goes idle. `ovf_flag` is set if `buf_full` was set. Only `ovf_clr` clears `ovf_flag`.
- R6: A `buf_rd` pulse clears `buf_full`. `buf_rdata` always shows the data register.
- R7: In 10-bit mode the first byte must be `11110,A9,A8,0` with bits [7:1] equal to the address register bits [7:1]. Once it is acknowledged, `ua_flag` is set and SCL is held low after the 9th fall until an `adr_wr` pulse. That write clears `ua_flag` and releases SCL.
- R8: The second 10-bit byte is compared with all 8 address register bits. On a match it is acknowledged, `ua_flag` is set and SCL is held until `adr_wr`. Following bytes are received as data. A mismatching low byte is not acknowledged.
- R9: A high byte with R/W=1 is acknowledged in 10-bit mode only after a full two-byte match that has not since been ended by a Stop. It then starts a read.
- R10: After a read address is acknowledged, SCL is held low from the 9th fall until `rel_set`. In that wait, `buf_wr` loads both the data register and the transmit shifter.
- R11: Transmit bits leave MSB first, and SDA changes only while SCL is low. SDA is released for the 9th clock.
- R12: The master's acknowledge is latched at the 9th SCL rise. A high level sends the block to idle with SCL free and no interrupt. A low level sets `irq_flag` and holds SCL again until `rel_set`.
- R13: In a write, each data byte after the address is acknowledged and loaded as in R2 when the flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low |
| ten_mode | input | 1 | 1 selects 10-bit addressing |
| adr_wr | input | 1 | Host write of the address register |
| adr_wdata | input | 8 | Address register write value |
| buf_wr | input | 1 | Host write of the data register (and transmit shifter) |
| buf_wdata | input | 8 | Data register write value |
| buf_rd | input | 1 | Host read strobe, clears buffer-full |
| buf_rdata | output | 8 | Data register contents |
| rel_set | input | 1 | Host releases a transmit clock stretch |
| ovf_clr | input | 1 | Clears the overflow flag |
| irq_clr | input | 1 | Clears the interrupt flag |
| buf_full | output | 1 | Data register holds an unread byte |
| ovf_flag | output | 1 | A byte completed while buffer-full was set |
| ua_flag | output | 1 | Host must rewrite the address register |
| rw_flag | output | 1 | Direction bit of the last accepted address |
| irq_flag | output | 1 | Byte event flag |

## Verification
The bench builds the block with three synchroniser stages. This lengthens the delay from a bus edge to the state change, so the sampling and stretch timing are tested with a real margin against the bench master's quarter-bit period. The reset address is 8'h84 (7-bit address 0x42). This lets the first transfers run with no address write, and checks that the parameter reaches the compare logic. The 10-bit sequences program their own address, 0x2B5, through the host port.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_UAWAIT,
        ST_RX,
        ST_TXWAIT,
        ST_TX,
        ST_TXACK
    } tgt_state_e;

    localparam int          BYTE_W   = 8;
    localparam int          CNT_W    = 4;
    localparam logic [4:0]  TEN_TAG  = 5'b11110;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int DEPTH = (STAGES < 2) ? 2 : STAGES;

    logic [DEPTH-1:0] scl_pipe;
    logic [DEPTH-1:0] sda_pipe;
    logic             scl_prev;
    logic             sda_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[DEPTH-2:0], scl_in};
            sda_pipe <= {sda_pipe[DEPTH-2:0], sda_in};
            scl_prev <= scl_pipe[DEPTH-1];
            sda_prev <= sda_pipe[DEPTH-1];
        end
    end

    assign scl_lvl   = scl_pipe[DEPTH-1];
    assign sda_lvl   = sda_pipe[DEPTH-1];
    assign scl_rise  = scl_lvl & ~scl_prev;
    assign scl_fall  = ~scl_lvl & scl_prev;
    assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/i2c_tgt_match.sv
module i2c_tgt_match
    import i2c_tgt_pkg::*;
(
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [BYTE_W-1:0] own_addr,
    input  logic              ten_mode,
    input  logic              low_phase,
    input  logic              ten_done,
    output logic              hit,
    output logic              is_read
);
    always_comb begin
        is_read = rx_byte[0] && !(ten_mode && low_phase);
        hit     = 1'b0;
        if (!ten_mode) begin
            hit = (rx_byte[7:1] == own_addr[7:1]);
        end else if (low_phase) begin
            hit = (rx_byte == own_addr);
        end else begin
            hit = (rx_byte[7:3] == TEN_TAG)
               && (rx_byte[7:1] == own_addr[7:1])
               && (!rx_byte[0] || ten_done);
        end
    end

endmodule

// File: rtl/i2c_target_ctl.sv
module i2c_target_ctl
    import i2c_tgt_pkg::*;
#(
    parameter int          SYNC_STAGES = 2,
    parameter logic [7:0]  RESET_ADDR  = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_oe,
    output logic       sda_oe,
    input  logic       ten_mode,
    input  logic       adr_wr,
    input  logic [7:0] adr_wdata,
    input  logic       buf_wr,
    input  logic [7:0] buf_wdata,
    input  logic       buf_rd,
    output logic [7:0] buf_rdata,
    input  logic       rel_set,
    input  logic       ovf_clr,
    input  logic       irq_clr,
    output logic       buf_full,
    output logic       ovf_flag,
    output logic       ua_flag,
    output logic       rw_flag,
    output logic       irq_flag
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W + 1);

    tgt_state_e        state, state_d, ack_then;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg, data_q, adr_q;
    logic              bf_q, ovf_q, ua_q, irq_q, rw_q;
    logic              low_phase, ten_done;
    logic              scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic              hit, is_read;
    logic              byte_end, ack_end, flags_free;

    i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_i),
        .sda_in    (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_tgt_match u_match (
        .rx_byte   (shreg),
        .own_addr  (adr_q),
        .ten_mode  (ten_mode),
        .low_phase (low_phase),
        .ten_done  (ten_done),
        .hit       (hit),
        .is_read   (is_read)
    );

    assign byte_end   = scl_fall && (bit_cnt == LAST_BIT);
    assign ack_end    = scl_fall && (bit_cnt == ACK_BIT);
    assign flags_free = !bf_q && !ovf_q;

    // next-state logic
    always_comb begin
        state_d = state;
        if (stop_det) begin
            state_d = ST_IDLE;
        end else if (start_det) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:   state_d = ST_IDLE;
                ST_ADDR:   if (byte_end) state_d = (hit && flags_free) ? ST_ACK : ST_IDLE;
                ST_RX:     if (byte_end) state_d = flags_free ? ST_ACK : ST_IDLE;
                ST_ACK:    if (ack_end)  state_d = ack_then;
                ST_UAWAIT: if (adr_wr)   state_d = low_phase ? ST_ADDR : ST_RX;
                ST_TXWAIT: if (rel_set)  state_d = ST_TX;
                ST_TX:     if (byte_end) state_d = ST_TXACK;
                ST_TXACK: begin
                    if (scl_rise && sda_lvl) state_d = ST_IDLE;
                    else if (ack_end)        state_d = ST_TXWAIT;
                end
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // datapath and host flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            shreg     <= '0;
            data_q    <= '0;
            adr_q     <= RESET_ADDR;
            bf_q      <= 1'b0;
            ovf_q     <= 1'b0;
            ua_q      <= 1'b0;
            irq_q     <= 1'b0;
            rw_q      <= 1'b0;
            low_phase <= 1'b0;
            ten_done  <= 1'b0;
            ack_then  <= ST_IDLE;
        end else begin
            if (start_det || stop_det || ack_end ||
                state == ST_IDLE || state == ST_UAWAIT || state == ST_TXWAIT)
                bit_cnt <= '0;
            else if (scl_rise)
                bit_cnt <= bit_cnt + 1'b1;

            if (adr_wr)  begin adr_q <= adr_wdata; ua_q <= 1'b0; end
            if (buf_wr)  data_q <= buf_wdata;
            if (buf_rd)  bf_q   <= 1'b0;
            if (ovf_clr) ovf_q  <= 1'b0;
            if (irq_clr) irq_q  <= 1'b0;

            if (stop_det) begin
                low_phase <= 1'b0;
                ten_done  <= 1'b0;
            end else if (start_det) begin
                low_phase <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            shreg <= {shreg[BYTE_W-2:0], sda_lvl};
                        end else if (byte_end) begin
                            if (hit && flags_free) begin
                                data_q   <= shreg;
                                bf_q     <= 1'b1;
                                rw_q     <= is_read;
                                ack_then <= is_read ? ST_TXWAIT
                                          : (ten_mode ? ST_UAWAIT : ST_RX);
                                if (low_phase) begin
                                    low_phase <= 1'b0;
                                    ten_done  <= 1'b1;
                                end else if (ten_mode && !is_read) begin
                                    low_phase <= 1'b1;
                                end
                            end else if (hit && bf_q) begin
                                ovf_q <= 1'b1;
                            end
                        end
                    end
                    ST_RX: begin
                        if (scl_rise) begin
                            shreg <= {shreg[BYTE_W-2:0], sda_lvl};
                        end else if (byte_end) begin
                            if (flags_free) begin
                                data_q   <= shreg;
                                bf_q     <= 1'b1;
                                ack_then <= ST_RX;
                            end else if (bf_q) begin
                                ovf_q <= 1'b1;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (ack_end) begin
                            irq_q <= 1'b1;
                            if (ack_then == ST_UAWAIT) ua_q <= 1'b1;
                        end
                    end
                    ST_TXWAIT: if (buf_wr) shreg <= buf_wdata;
                    ST_TX:     if (scl_fall && bit_cnt != '0)
                                   shreg <= {shreg[BYTE_W-2:0], 1'b1};
                    ST_TXACK:  if (ack_end) irq_q <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    // line drive and flag outputs
    always_comb begin
        scl_oe    = (state == ST_UAWAIT) || (state == ST_TXWAIT);
        sda_oe    = (state == ST_ACK) || ((state == ST_TX) && !shreg[BYTE_W-1]);
        buf_rdata = data_q;
        buf_full  = bf_q;
        ovf_flag  = ovf_q;
        ua_flag   = ua_q;
        rw_flag   = rw_q;
        irq_flag  = irq_q;
    end

endmodule

// File: rtl/i2c_target_chk.sv
module i2c_target_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_oe,
    input logic sda_oe,
    input logic scl_lvl,
    input logic scl_fall,
    input logic buf_rd,
    input logic buf_full,
    input logic ovf_flag,
    input logic ua_flag,
    input logic irq_flag
);
    // R11: SDA drive never changes while synchronised SCL stays high
    assert_sda_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && $past(scl_lvl)) |-> $stable(sda_oe));

    // R5: overflow is never accompanied by an acknowledge
    assert_no_ack_on_ovf_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> !sda_oe);

    // R7: update-address pending means SCL is held
    assert_ua_stretch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ua_flag |-> scl_oe);

    // R3: interrupt rises only after an SCL fall
    assert_irq_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> !scl_lvl);

    // R6: a host read clears buffer-full when no byte completes
    assert_rd_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_full && buf_rd && !scl_fall) |=> !buf_full);

    // R10: stretching starts only while SCL is already low
    assert_stretch_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe) |-> !scl_lvl);

    // R2: the two line enables are never both active
    assert_lines_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(scl_oe && sda_oe));

endmodule

bind i2c_target_ctl i2c_target_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .scl_lvl  (scl_lvl),
    .scl_fall (scl_fall),
    .buf_rd   (buf_rd),
    .buf_full (buf_full),
    .ovf_flag (ovf_flag),
    .ua_flag  (ua_flag),
    .irq_flag (irq_flag)
);

// File: tb/i2c_target_ctl_test.sv
module i2c_target_ctl_test;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic scl_oe, sda_oe, scl_bus, sda_bus;
    logic ten_mode = 1'b0, adr_wr = 1'b0, buf_wr = 1'b0, buf_rd = 1'b0;
    logic rel_set = 1'b0, ovf_clr = 1'b0, irq_clr = 1'b0;
    logic [7:0] adr_wdata = '0, buf_wdata = '0, buf_rdata;
    logic buf_full, ovf_flag, ua_flag, rw_flag, irq_flag;

    int compared = 0, mismatched = 0;
    bit done = 0, run_bus_chk = 0;
    logic prev_scl = 1'b1, prev_sda_oe = 1'b0;

    // behavioural expectation of the host-visible state
    logic e_bf = 0, e_ovf = 0, e_irq = 0, e_ua = 0, e_rw = 0;
    logic [7:0] e_data = 8'h00;

    assign scl_bus = m_scl & ~scl_oe;
    assign sda_bus = m_sda & ~sda_oe;

    always #4 clk = ~clk;

    i2c_target_ctl #(.SYNC_STAGES(3), .RESET_ADDR(8'h84)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .ten_mode(ten_mode),
        .adr_wr(adr_wr), .adr_wdata(adr_wdata), .buf_wr(buf_wr),
        .buf_wdata(buf_wdata), .buf_rd(buf_rd), .buf_rdata(buf_rdata),
        .rel_set(rel_set), .ovf_clr(ovf_clr), .irq_clr(irq_clr),
        .buf_full(buf_full), .ovf_flag(ovf_flag), .ua_flag(ua_flag),
        .rw_flag(rw_flag), .irq_flag(irq_flag)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_state(input string req, input logic e_hold);
        chk(req, "buf_full", buf_full, e_bf);
        chk(req, "ovf_flag", ovf_flag, e_ovf);
        chk(req, "irq_flag", irq_flag, e_irq);
        chk(req, "ua_flag",  ua_flag,  e_ua);
        chk(req, "rw_flag",  rw_flag,  e_rw);
        chk(req, "buf_rdata", buf_rdata, e_data);
        chk(req, "scl_oe",   scl_oe,   e_hold);
    endtask

    // R11: every clock, SDA drive holds while the bus SCL stays high
    always @(negedge clk) begin
        if (run_bus_chk) begin
            if (scl_bus && prev_scl) chk("R11", "sda_oe stable at SCL high", sda_oe, prev_sda_oe);
            prev_scl    <= scl_bus;
            prev_sda_oe <= sda_oe;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_scl_high();
        while (!scl_bus) @(negedge clk);
    endtask

    task automatic bit_x(input logic b, output logic got);
        m_sda = b; idle(Q);
        m_scl = 1'b1; idle(1); wait_scl_high(); idle(Q);
        got = sda_bus;
        m_scl = 1'b0; idle(Q);
    endtask

    task automatic m_start();
        m_sda = 1'b1; idle(Q);
        m_scl = 1'b1; wait_scl_high(); idle(Q);
        m_sda = 1'b0; idle(Q);
        m_scl = 1'b0; idle(Q);
    endtask

    task automatic m_stop();
        m_sda = 1'b0; idle(Q);
        m_scl = 1'b1; wait_scl_high(); idle(Q);
        m_sda = 1'b1; idle(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        logic g;
        for (int i = 7; i >= 0; i--) bit_x(v[i], g);
        bit_x(1'b1, g);
        acked = !g;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] v);
        logic g;
        for (int i = 7; i >= 0; i--) begin bit_x(1'b1, g); v[i] = g; end
        bit_x(mack, g);
    endtask

    task automatic host_rd();     @(negedge clk) buf_rd = 1;  @(negedge clk) buf_rd = 0;  e_bf = 0;  endtask
    task automatic host_irq_clr(); @(negedge clk) irq_clr = 1; @(negedge clk) irq_clr = 0; e_irq = 0; endtask
    task automatic host_ovf_clr(); @(negedge clk) ovf_clr = 1; @(negedge clk) ovf_clr = 0; e_ovf = 0; endtask
    task automatic host_rel();    @(negedge clk) rel_set = 1; @(negedge clk) rel_set = 0; endtask
    task automatic host_adr(input logic [7:0] a);
        @(negedge clk) begin adr_wr = 1; adr_wdata = a; end
        @(negedge clk) adr_wr = 0; e_ua = 0;
    endtask
    task automatic host_wr(input logic [7:0] d);
        @(negedge clk) begin buf_wr = 1; buf_wdata = d; end
        @(negedge clk) buf_wr = 0; e_data = d;
    endtask

    // model update for an accepted byte
    task automatic took(input logic [7:0] v, input logic is_addr, input logic ua);
        e_bf = 1; e_irq = 1; e_data = v;
        if (is_addr) e_rw = v[0];
        if (ua) e_ua = 1;
    endtask

    initial begin
        repeat (120000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic ak;
        logic [7:0] rx;
        idle(3);
        // R1: reset state
        chk("R1", "sda_oe at reset", sda_oe, 0);
        chk_state("R1", 0);
        rst_n = 1'b1;
        idle(5);
        run_bus_chk = 1;

        // R2 / R3 / R6 / R13 / R5: 7-bit write, then overflow
        m_start();
        send_byte(8'h84, ak); took(8'h84, 1, 0);
        chk("R2", "address ack", ak, 1);
        chk_state("R2", 0);
        host_rd(); host_irq_clr();
        chk_state("R6", 0);
        send_byte(8'h5A, ak); took(8'h5A, 0, 0);
        chk("R13", "data ack", ak, 1);
        chk_state("R13", 0);
        send_byte(8'h33, ak); e_ovf = 1;
        chk("R5", "no ack while full", ak, 0);
        chk_state("R5", 0);
        send_byte(8'h11, ak);
        chk("R5", "idle after overflow", ak, 0);
        m_stop();
        host_ovf_clr(); host_rd(); host_irq_clr();
        chk_state("R5", 0);

        // R4: mismatch, then an address-like byte before Start
        m_start();
        send_byte(8'h90, ak);
        chk("R4", "mismatch no ack", ak, 0);
        send_byte(8'h84, ak);
        chk("R4", "ignored until Start", ak, 0);
        chk_state("R4", 0);
        m_stop();

        // R1: Repeated Start re-arms after a mismatch
        m_start();
        send_byte(8'hA0, ak);
        m_start();
        send_byte(8'h84, ak); took(8'h84, 1, 0);
        chk("R1", "ack after repeated start", ak, 1);
        host_rd(); host_irq_clr();
        m_stop();
        chk("R1", "sda released after stop", sda_oe, 0);
        chk_state("R1", 0);

        // R10 / R11 / R12: 7-bit read
        m_start();
        send_byte(8'h85, ak); took(8'h85, 1, 0);
        chk("R10", "read address ack", ak, 1);
        chk_state("R10", 1);
        idle(60);
        chk("R10", "still stretching", scl_oe, 1);
        host_rd(); host_irq_clr(); host_wr(8'hC3);
        chk_state("R10", 1);
        host_rel();
        recv_byte(1'b0, rx); e_irq = 1;
        chk("R11", "transmit byte 1", rx, 8'hC3);
        chk_state("R12", 1);
        host_irq_clr(); host_wr(8'h3C); host_rel();
        recv_byte(1'b1, rx);
        chk("R11", "transmit byte 2", rx, 8'h3C);
        chk_state("R12", 0);
        chk("R12", "sda released after NACK", sda_oe, 0);
        m_stop();

        // R7 / R8 / R9: 10-bit addressing, address 0x2B5
        ten_mode = 1'b1;
        host_adr(8'hF4);
        m_start();
        send_byte(8'hF5, ak);
        chk("R9", "read before full match", ak, 0);
        m_stop();
        chk_state("R9", 0);

        m_start();
        send_byte(8'hF4, ak); took(8'hF4, 1, 1);
        chk("R7", "high byte ack", ak, 1);
        chk_state("R7", 1);
        idle(40);
        chk("R7", "held for update", scl_oe, 1);
        host_rd(); host_irq_clr(); host_adr(8'hB5);
        chk_state("R7", 0);
        send_byte(8'hB5, ak); took(8'hB5, 0, 1);
        chk("R8", "low byte ack", ak, 1);
        chk_state("R8", 1);
        host_rd(); host_irq_clr(); host_adr(8'hF4);
        chk_state("R8", 0);
        send_byte(8'h77, ak); took(8'h77, 0, 0);
        chk("R8", "data after 10-bit match", ak, 1);
        chk_state("R8", 0);
        host_rd(); host_irq_clr();
        m_start();
        send_byte(8'hF5, ak); took(8'hF5, 1, 0);
        chk("R9", "10-bit read ack", ak, 1);
        chk_state("R9", 1);
        host_rd(); host_irq_clr(); host_wr(8'h96); host_rel();
        recv_byte(1'b1, rx);
        chk("R9", "10-bit read data", rx, 8'h96);
        m_stop();

        // R8: wrong low byte is refused
        m_start();
        send_byte(8'hF4, ak); took(8'hF4, 1, 1);
        host_rd(); host_irq_clr(); host_adr(8'hB5);
        send_byte(8'hB4, ak);
        chk("R8", "low byte mismatch", ak, 0);
        chk_state("R8", 0);
        m_stop();
        host_adr(8'hF4);

        done = 1;
        run_bus_chk = 0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule